// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters. A free-running tick enable (nominally 32.768 kHz) feeds a sub-second prescaler. Once per second the prescaler emits a single-cycle strobe that advances seconds. Carries then ripple through minutes, hours, date, month and year, and the day of week advances whenever the date does. Hours can run in a 24-hour format or in a 12-hour format with an afternoon flag; the hour byte itself selects the format. Month ends follow the calendar, including February of leap years, for two-digit years 00–99 taken as 2000–2099.

A host sets the time through a valid/ready load port that writes one field per accepted transfer. `ld_ready` is low during reset and high from the first clock after it, so a host never has to wait once the block is out of reset. A transfer takes place on a rising edge where both `ld_valid` and `ld_ready` are high. While `ld_valid` is low, `ld_sel` and `ld_data` are ignored. Writing the seconds field also restarts the sub-second prescaler. Bit 7 of the seconds byte is a halt flag that freezes the whole chain.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (24-hour), date 01, month 01, day of week 01, year 00, and `ld_ready` is high from the first clock after reset is released.
- R2: The prescaler counts `TICKS_PER_SEC` clocks with `tick_en` high. On the last of them `sec_stb` is high for one cycle, and the seconds advance at that same edge. Clocks with `tick_en` low neither count nor strobe, and no field changes except at a strobe or a load.
- R3: Seconds (bits 6:0) and minutes run 00–59 in BCD. Each wraps to 00 and carries into the next field; the seconds halt bit is kept across the wrap.
- R4: With hour bit 7 = 0 (24-hour format), hour bits 5:0 run 00–23 in BCD, and 23 wrapping to 00 advances the date.
- R5: With hour bit 7 = 1 (12-hour format), bit 5 is the afternoon flag (1 = PM) and bits 4:0 run 01–12 in BCD. The step 11→12 toggles the flag, and the step 12→01 keeps it. The step from 11 PM to 12 AM advances the date.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 or 29 in February. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: February has 29 days when the BCD year is divisible by 4 (00, 04, 08, 12, … 96) and 28 days otherwise.
- R8: Day of week advances by one with each date advance and wraps from 07 to 01.
- R9: When seconds bit 7 is 1, the prescaler and every field hold and `sec_stb` stays low. Loading a seconds value with bit 7 = 0 resumes counting.
- R10: `ld_sel` encoding: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 day of week, 6 year. Loaded values are masked to the field: minutes bit 7, hour bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3 always read 0.
- R11: A seconds load clears the prescaler, so the next `sec_stb` comes `TICKS_PER_SEC` tick-enabled clocks after the load edge.
- R12: A load to a field wins over that field's increment in the same cycle, while the other fields still advance. Carries are taken from the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-second tick enable (one per 1/TICKS_PER_SEC s) |
| ld_valid | input | 1 | Load transfer offered |
| ld_ready | output | 1 | Load transfer can be accepted |
| ld_sel | input | 3 | Field selector for the load |
| ld_data | input | 8 | Packed-BCD value for the selected field |
| sec_o | output | 8 | Seconds, bit 7 halt flag |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour, bit 7 format, bit 5 PM or tens-of-20 |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| dow_o | output | 8 | Day of week 1–7 |
| year_o | output | 8 | Two-digit year |
| sec_stb | output | 1 | One-cycle once-per-second strobe |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 4, so each second takes four clocks. This makes every rollover reachable within a few dozen cycles after the fields are preloaded to just before it: midnight, month ends, February in leap and common years, year 99, and both hour formats. The small prescaler also lets the bench count the exact strobe spacing after a seconds load, and place a minutes load on the very cycle of a seconds wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef enum logic [SEL_W-1:0] {
    F_SEC  = 'd0,
    F_MIN  = 'd1,
    F_HOUR = 'd2,
    F_DATE = 'd3,
    F_MON  = 'd4,
    F_DOW  = 'd5,
    F_YEAR = 'd6
  } field_e;

  // two-digit BCD increment, no wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year 2000..2099: divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mo, input logic [7:0] y);
    if (mo == 8'h02) return is_leap(y) ? 8'h29 : 8'h28;
    if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

  // returns {day_carry, next_hour}
  function automatic logic [8:0] hour_next(input logic [7:0] h);
    logic [7:0] t;
    if (h[7]) begin
      if (h[4:0] == 5'h12) return {1'b0, 1'b1, 1'b0, h[5], 5'h01};
      if (h[4:0] == 5'h11) return {h[5], 1'b1, 1'b0, ~h[5], 5'h12};
      t = bcd_inc({3'b000, h[4:0]});
      return {1'b0, 1'b1, 1'b0, h[5], t[4:0]};
    end
    if (h[5:0] == 6'h23) return {1'b1, 8'h00};
    t = bcd_inc({2'b00, h[5:0]});
    return {1'b0, 2'b00, t[5:0]};
  endfunction

  function automatic logic [7:0] load_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      F_SEC:   return 8'hFF;
      F_MIN:   return 8'h7F;
      F_HOUR:  return 8'hBF;
      F_DATE:  return 8'h3F;
      F_MON:   return 8'h1F;
      F_DOW:   return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clr,
  output logic carry
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic at_last;

  assign at_last = (cnt_q == LAST);
  assign carry   = tick_en & run & ~clr & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (tick_en && run) cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       we_sec,
  input  logic       we_min,
  input  logic       we_hour,
  input  logic [7:0] wdata,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  logic       min_tick, hour_tick;
  logic [7:0] sec_inc, min_inc;
  logic [8:0] hour_nx;

  assign sec_inc   = bcd_inc({1'b0, sec_q[6:0]});
  assign min_inc   = bcd_inc(min_q);
  assign hour_nx   = hour_next(hour_q);
  assign min_tick  = sec_tick & (sec_q[6:0] == 7'h59);
  assign hour_tick = min_tick & (min_q == 8'h59);
  assign day_carry = hour_tick & hour_nx[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (we_sec)        sec_q <= wdata;
      else if (sec_tick) sec_q <= {sec_q[7], (sec_q[6:0] == 7'h59) ? 7'h00 : sec_inc[6:0]};
      if (we_min)        min_q <= wdata;
      else if (min_tick) min_q <= (min_q == 8'h59) ? 8'h00 : min_inc;
      if (we_hour)        hour_q <= wdata;
      else if (hour_tick) hour_q <= hour_nx[7:0];
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_tick,
  input  logic       we_date,
  input  logic       we_mon,
  input  logic       we_dow,
  input  logic       we_year,
  input  logic [7:0] wdata,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);
  logic month_tick, year_tick;

  assign month_tick = day_tick & (date_q == last_day(mon_q, year_q));
  assign year_tick  = month_tick & (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (we_date)       date_q <= wdata;
      else if (day_tick) date_q <= month_tick ? 8'h01 : bcd_inc(date_q);
      if (we_mon)          mon_q <= wdata;
      else if (month_tick) mon_q <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
      if (we_dow)        dow_q <= wdata;
      else if (day_tick) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (we_year)        year_q <= wdata;
      else if (year_tick) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [7:0]       ld_data,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       date_o,
  output logic [7:0]       month_o,
  output logic [7:0]       dow_o,
  output logic [7:0]       year_o,
  output logic             sec_stb
);
  logic                  rdy_q, ld_go, day_carry;
  logic [NUM_FIELDS-1:0] we;
  logic [7:0]            wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign ld_ready = rdy_q;
  assign ld_go    = ld_valid & rdy_q;
  assign wdata    = ld_data & load_mask(ld_sel);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_we
    assign we[i] = ld_go && (ld_sel == SEL_W'(i));
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .run(~sec_o[7]), .clr(we[F_SEC]), .carry(sec_stb)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_stb),
    .we_sec(we[F_SEC]), .we_min(we[F_MIN]), .we_hour(we[F_HOUR]),
    .wdata(wdata), .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_tick(day_carry),
    .we_date(we[F_DATE]), .we_mon(we[F_MON]), .we_dow(we[F_DOW]),
    .we_year(we[F_YEAR]), .wdata(wdata),
    .date_q(date_o), .mon_q(month_o), .dow_q(dow_o), .year_q(year_o)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic [2:0] ld_sel,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] dow_o,
  input logic [7:0] year_o,
  input logic       sec_stb
);
  logic ld_go;
  assign ld_go = ld_valid & ld_ready;

  // R9: a halted chain never strobes
  a_r9_halt_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] |-> !sec_stb);

  // R3: seconds wrap to 00 when not overwritten
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && sec_o[6:0] == 7'h59 && !(ld_go && ld_sel == 3'd0)) |=> sec_o[6:0] == 7'h00);

  // R4: 23:59:59 in 24-hour format goes to hour 00
  a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && !ld_go && hour_o == 8'h23 && min_o == 8'h59 && sec_o[6:0] == 7'h59)
    |=> hour_o == 8'h00);

  // R10: bits outside the fields stay zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    date_o[7:6] == 2'b00 && month_o[7:5] == 3'b000 && dow_o[7:3] == 5'b00000 &&
    min_o[7] == 1'b0 && hour_o[6] == 1'b0);

  // R11: a seconds load restarts the prescaler
  a_r11_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (TICKS_PER_SEC > 1 && ld_go && ld_sel == 3'd0) |=> !sec_stb);

  // R2: no field moves without a strobe or a load
  a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_stb && !ld_go) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
    $stable(date_o) && $stable(month_o) && $stable(dow_o) && $stable(year_o)));
endmodule

bind bcd_rtc_core rtc_core_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_sel(ld_sel), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .date_o(date_o), .month_o(month_o), .dow_o(dow_o), .year_o(year_o),
  .sec_stb(sec_stb)
);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  localparam int TPS = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, ld_valid = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic       ld_ready, sec_stb;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o;

  int total = 0, bad = 0;
  logic [55:0] exp_q[$];
  string       tag_q[$];

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .dow_o(dow_o), .year_o(year_o), .sec_stb(sec_stb)
  );

  always #5 clk = ~clk;

  function automatic logic [55:0] snap();
    return {sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o};
  endfunction

  // driver side: queue an expected snapshot, monitor compares it now
  task automatic expect_now(string tag, logic [55:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    #1;
  endtask

  initial begin : monitor
    forever begin
      logic [55:0] e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (snap() !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, snap(), e);
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = s; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dt, mo, dw, y);
    load(3'd0, 8'h80);
    load(3'd1, m); load(3'd2, h); load(3'd3, dt);
    load(3'd4, mo); load(3'd5, dw); load(3'd6, y);
    load(3'd0, s);
  endtask

  task automatic run_secs(input int n);
    for (int k = 0; k < n; k++) begin
      while (!sec_stb) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic midnight(string tag, input logic [7:0] dt, mo, dw, y,
                          input logic [7:0] edt, emo, edw, ey);
    set_time(8'h59, 8'h59, 8'h23, dt, mo, dw, y);
    run_secs(1);
    expect_now(tag, {8'h00, 8'h00, 8'h00, edt, emo, edw, ey});
  endtask

  initial begin : watchdog
    #1000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_now("R1 reset fields", {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    check_val("R1 ld_ready", int'(ld_ready), 1);
    tick_en = 1'b1;

    // R11 + R2: strobe spacing after a seconds load
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    n = 0;
    while (!sec_stb) begin @(negedge clk); n++; end
    check_val("R11 first strobe after load", n, TPS - 1);
    @(negedge clk);
    n = 1;
    while (!sec_stb) begin @(negedge clk); n++; end
    check_val("R2 strobe period", n, TPS);
    @(negedge clk);
    expect_now("R2 two seconds advanced", {8'h12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    // R2 tick_en low: no counting
    tick_en = 1'b0;
    n = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (sec_stb) n++; end
    check_val("R2 no strobe without tick_en", n, 0);
    expect_now("R2 held without tick_en", {8'h12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    tick_en = 1'b1;

    // R3 seconds/minutes roll into hour
    set_time(8'h58, 8'h59, 8'h05, 8'h10, 8'h06, 8'h02, 8'h21);
    run_secs(2);
    expect_now("R3 sec/min wrap", {8'h00, 8'h00, 8'h06, 8'h10, 8'h06, 8'h02, 8'h21});

    // R4 24-hour format
    set_time(8'h59, 8'h59, 8'h09, 8'h10, 8'h06, 8'h02, 8'h21);
    run_secs(1);
    expect_now("R4 hour 09->10", {8'h00, 8'h00, 8'h10, 8'h10, 8'h06, 8'h02, 8'h21});
    midnight("R4 23->00 advances date", 8'h15, 8'h03, 8'h03, 8'h24, 8'h16, 8'h03, 8'h04, 8'h24);

    // R5 12-hour format
    set_time(8'h59, 8'h59, 8'h91, 8'h05, 8'h07, 8'h02, 8'h22);
    run_secs(1);
    expect_now("R5 11AM->12PM", {8'h00, 8'h00, 8'hB2, 8'h05, 8'h07, 8'h02, 8'h22});
    set_time(8'h59, 8'h59, 8'hB2, 8'h05, 8'h07, 8'h02, 8'h22);
    run_secs(1);
    expect_now("R5 12PM->1PM", {8'h00, 8'h00, 8'hA1, 8'h05, 8'h07, 8'h02, 8'h22});
    set_time(8'h59, 8'h59, 8'hB1, 8'h05, 8'h07, 8'h02, 8'h22);
    run_secs(1);
    expect_now("R5 11PM->12AM next day", {8'h00, 8'h00, 8'h92, 8'h06, 8'h07, 8'h03, 8'h22});
    set_time(8'h59, 8'h59, 8'h89, 8'h05, 8'h07, 8'h02, 8'h22);
    run_secs(1);
    expect_now("R5 9AM->10AM", {8'h00, 8'h00, 8'h90, 8'h05, 8'h07, 8'h02, 8'h22});

    // R6 month ends
    midnight("R6 Apr30", 8'h30, 8'h04, 8'h04, 8'h25, 8'h01, 8'h05, 8'h05, 8'h25);
    midnight("R6 Sep30", 8'h30, 8'h09, 8'h04, 8'h25, 8'h01, 8'h10, 8'h05, 8'h25);
    midnight("R6 Mar30", 8'h30, 8'h03, 8'h04, 8'h25, 8'h31, 8'h03, 8'h05, 8'h25);
    midnight("R6 Jan31", 8'h31, 8'h01, 8'h04, 8'h25, 8'h01, 8'h02, 8'h05, 8'h25);
    midnight("R6 Dec31 y99", 8'h31, 8'h12, 8'h04, 8'h99, 8'h01, 8'h01, 8'h05, 8'h00);

    // R7 February
    midnight("R7 Feb28 y23", 8'h28, 8'h02, 8'h01, 8'h23, 8'h01, 8'h03, 8'h02, 8'h23);
    midnight("R7 Feb28 y24", 8'h28, 8'h02, 8'h01, 8'h24, 8'h29, 8'h02, 8'h02, 8'h24);
    midnight("R7 Feb29 y24", 8'h29, 8'h02, 8'h01, 8'h24, 8'h01, 8'h03, 8'h02, 8'h24);
    midnight("R7 Feb28 y00", 8'h28, 8'h02, 8'h01, 8'h00, 8'h29, 8'h02, 8'h02, 8'h00);
    midnight("R7 Feb28 y12", 8'h28, 8'h02, 8'h01, 8'h12, 8'h29, 8'h02, 8'h02, 8'h12);
    midnight("R7 Feb28 y10", 8'h28, 8'h02, 8'h01, 8'h10, 8'h01, 8'h03, 8'h02, 8'h10);

    // R8 day of week wrap
    midnight("R8 dow 7->1", 8'h20, 8'h05, 8'h07, 8'h30, 8'h21, 8'h05, 8'h01, 8'h30);

    // R9 halt
    set_time(8'h85, 8'h10, 8'h08, 8'h02, 8'h02, 8'h02, 8'h02);
    n = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (sec_stb) n++; end
    check_val("R9 no strobe while halted", n, 0);
    expect_now("R9 fields frozen", {8'h85, 8'h10, 8'h08, 8'h02, 8'h02, 8'h02, 8'h02});
    load(3'd0, 8'h05);
    run_secs(1);
    expect_now("R9 resume", {8'h06, 8'h10, 8'h08, 8'h02, 8'h02, 8'h02, 8'h02});

    // R10 masks and ignored data without valid
    load(3'd0, 8'h80);
    load(3'd1, 8'hFF); load(3'd2, 8'hFF); load(3'd3, 8'hFF);
    load(3'd4, 8'hFF); load(3'd5, 8'hFF); load(3'd6, 8'h47);
    @(negedge clk);
    ld_valid = 1'b0; ld_sel = 3'd1; ld_data = 8'h44;
    @(negedge clk);
    expect_now("R10 masked loads", {8'h80, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'h07, 8'h47});

    // R12 load beats increment in the same cycle
    set_time(8'h57, 8'h10, 8'h08, 8'h03, 8'h03, 8'h03, 8'h03);
    run_secs(2);
    while (!sec_stb) @(negedge clk);
    ld_valid = 1'b1; ld_sel = 3'd1; ld_data = 8'h30;
    @(negedge clk);
    ld_valid = 1'b0;
    expect_now("R12 load wins, sec still wraps", {8'h00, 8'h30, 8'h08, 8'h03, 8'h03, 8'h03, 8'h03});

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule